// File: doc/BRIEF.md
# Single-Channel PWM Counter with Edge and Center Alignment

This block is one pulse-width modulation channel. It keeps three writable settings: a mode word, a duty value and a period value. Its 20-bit counter can be read back at any time. The counter advances on a tick taken from one of several sources:

- a power-of-two division of the block clock, from divide-by-1 to divide-by-1024;
- one of two externally generated clock-enable strobes, supplied by a shared divider that is not part of this block.

The counter either wraps like a sawtooth (edge-aligned) or climbs and then descends like a triangle (center-aligned). The output is high while the counter is below the duty value. A one-cycle event marks the completion of each period.

New duty, period and mode values written while the channel runs are held in shadow storage. They take effect only when the current period ends, so no waveform is ever cut short or stretched. When the channel enable is low:

- the counter is parked at zero;
- the output is low;
- the internal prescaler restarts;
- shadow values, including a write in that same cycle, pass straight to the working copies.

The register decode is outside this block. A parent places the four slots in the order mode, duty, period, counter and drives the write strobe, the slot select and the data.

Top module: `pwm_ch`

## Requirements
- R1: After reset the counter reads 0, the output and the event are low, and mode, duty and period are all 0. Mode 0 means divide-by-1 ticks with edge alignment.
- R2: While `chan_en` is low, the counter is held at 0, the output is low, no event is produced, and the prescaler restarts. After re-enable, the first divided tick lands on the 2^n-th enabled cycle.
- R3: Mode bits [3:0] choose the tick source. Values 0 to 10 give one tick every 2^n enabled cycles. Value 11 uses `tick_a` and value 12 uses `tick_b`. Values 13 to 15 give no ticks, so the counter stays frozen. Without a tick the counter does not change.
- R4: With mode bit 4 clear (edge-aligned) and period P ≥ 1, the counter steps 0, 1, …, P−1 on successive ticks and then returns to 0.
- R5: With mode bit 4 set (center-aligned) and P ≥ 1, the counter steps 0, 1, …, P, P−1, …, 1 and back to 0. One output period therefore spans 2P ticks, twice the edge-aligned span.
- R6: `pwm_o` is high exactly when the channel is enabled and the counter value shown in the same cycle is below the working duty value. Duty 0 keeps it low, and a duty above the count range keeps it high.
- R7: `evt_o` is a one-cycle pulse in the cycle the counter shows 0 after completing a period. This is the edge-aligned wrap or the center-aligned bottom.
- R8: With period 0 the counter stays at 0 and an event follows every tick.
- R9: Writes while enabled take effect at the next period boundary. Writes while disabled take effect at once. The slot select is 0 for mode, 1 for duty, 2 for period and 3 for counter.
- R10: A write landing in the same cycle as a period-boundary tick is stored but not used at that boundary. It takes effect at the following boundary.
- R11: A write to slot 3 (counter) is ignored: counter sequence, duty, period and mode are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| chan_en | input | 1 | Channel run enable |
| tick_a | input | 1 | First external clock-enable strobe |
| tick_b | input | 1 | Second external clock-enable strobe |
| wr_en | input | 1 | Setting write strobe |
| wr_sel | input | 2 | Slot select: 0 mode, 1 duty, 2 period, 3 counter |
| wr_data | input | 20 | Write data |
| pwm_o | output | 1 | Waveform output |
| cnt_o | output | 20 | Counter readback |
| evt_o | output | 1 | End-of-period pulse |

## Verification
A setting write and a period-boundary tick can fall in the same cycle. The bench provokes this by writing a new period on the exact enabled cycle on which the counter wraps. An arithmetic model applies the boundary load from the old shadow before it applies the write, so the expected counter keeps the old span for one more period. Every cycle, the bench compares counter, output and event against this model across sweeps of alignment, period, duty and tick source.

// File: rtl/pwm_ch_pkg.sv
package pwm_ch_pkg;

  // Width of the tick-source field inside the mode word.
  localparam int SEL_W = 4;

  typedef enum logic [1:0] {
    REG_MODE = 2'd0,
    REG_DUTY = 2'd1,
    REG_PRD  = 2'd2,
    REG_CNT  = 2'd3
  } reg_sel_e;

  // Packed so that center lands on bit 4 and src on bits [3:0].
  typedef struct packed {
    logic             center;
    logic [SEL_W-1:0] src;
  } mode_t;

  typedef enum logic {
    DIR_UP = 1'b0,
    DIR_DN = 1'b1
  } dir_e;

endpackage

// File: rtl/pwm_ch_tick.sv
module pwm_ch_tick
  import pwm_ch_pkg::*;
#(
  parameter int PRE_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [SEL_W-1:0] src,
  input  logic             ext_a,
  input  logic             ext_b,
  output logic             tick_o
);

  localparam int N_DIV  = PRE_W + 1;
  localparam int CODE_A = N_DIV;
  localparam int CODE_B = N_DIV + 1;

  logic [PRE_W-1:0] pre_q;
  logic [N_DIV-1:0] div_hit;
  logic             tick;

  // Free-running prescaler, restarted whenever the channel is idle.
  always_ff @(posedge clk) begin
    if (rst || !en) pre_q <= '0;
    else            pre_q <= pre_q + PRE_W'(1);
  end

  // One strobe per power of two: set when the low n bits are all ones.
  generate
    for (genvar g = 0; g < N_DIV; g++) begin : g_div
      if (g == 0) begin : g_full
        assign div_hit[g] = 1'b1;
      end else begin : g_part
        assign div_hit[g] = &pre_q[g-1:0];
      end
    end
  endgenerate

  always_comb begin
    tick = 1'b0;
    if (en) begin
      for (int i = 0; i < N_DIV; i++) begin
        if (src == SEL_W'(i)) tick = div_hit[i];
      end
      if (src == SEL_W'(CODE_A)) tick = ext_a;
      if (src == SEL_W'(CODE_B)) tick = ext_b;
    end
  end

  assign tick_o = tick;

  // R3: a divide-by-two source never ticks on two cycles in a row.
  a_r3_half_rate: assert property (@(posedge clk) disable iff (rst)
    (en && src == SEL_W'(1) && tick_o) |=> (!tick_o || !$stable(src)));

endmodule

// File: rtl/pwm_ch_regs.sv
module pwm_ch_regs
  import pwm_ch_pkg::*;
#(
  parameter int CNT_W = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             load,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  output mode_t            mode_act,
  output logic [CNT_W-1:0] prd_act,
  output logic [CNT_W-1:0] duty_nxt
);

  localparam int MODE_W = $bits(mode_t);

  mode_t            mode_sh, mode_q, mode_src, mode_nxt;
  logic [CNT_W-1:0] duty_sh, duty_q, duty_src;
  logic [CNT_W-1:0] prd_sh, prd_q, prd_src, prd_nxt;
  logic             hit_mode, hit_duty, hit_prd;

  assign hit_mode = wr_en && (wr_sel == REG_MODE);
  assign hit_duty = wr_en && (wr_sel == REG_DUTY);
  assign hit_prd  = wr_en && (wr_sel == REG_PRD);

  // An idle channel takes a same-cycle write straight through to its
  // working copy. A running channel loads only the stored shadow.
  assign mode_src = (!en && hit_mode) ? mode_t'(wr_data[MODE_W-1:0]) : mode_sh;
  assign duty_src = (!en && hit_duty) ? wr_data : duty_sh;
  assign prd_src  = (!en && hit_prd)  ? wr_data : prd_sh;

  assign mode_nxt = load ? mode_src : mode_q;
  assign duty_nxt = load ? duty_src : duty_q;
  assign prd_nxt  = load ? prd_src  : prd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_sh <= '0;
      duty_sh <= '0;
      prd_sh  <= '0;
      mode_q  <= '0;
      duty_q  <= '0;
      prd_q   <= '0;
    end else begin
      if (hit_mode) mode_sh <= mode_t'(wr_data[MODE_W-1:0]);
      if (hit_duty) duty_sh <= wr_data;
      if (hit_prd)  prd_sh  <= wr_data;
      mode_q <= mode_nxt;
      duty_q <= duty_nxt;
      prd_q  <= prd_nxt;
    end
  end

  assign mode_act = mode_q;
  assign prd_act  = prd_q;

  // R9: working copies hold between period boundaries.
  a_r9_hold_active: assert property (@(posedge clk) disable iff (rst)
    (en && !load) |=> ($stable(duty_q) && $stable(prd_q) && $stable(mode_q)));

  // R11: the counter slot reaches no stored setting.
  a_r11_cnt_slot_inert: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel == REG_CNT) |=>
      ($stable(duty_sh) && $stable(prd_sh) && $stable(mode_sh)));

endmodule

// File: rtl/pwm_ch_count.sv
module pwm_ch_count
  import pwm_ch_pkg::*;
#(
  parameter int CNT_W = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             tick,
  input  logic             center,
  input  logic [CNT_W-1:0] prd,
  input  logic [CNT_W-1:0] duty_nxt,
  output logic             wrap_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             pwm_o,
  output logic             evt_o
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_n;
  dir_e             dir_q, dir_n;
  logic             pwm_q, evt_q, wrap;

  always_comb begin
    cnt_n = cnt_q;
    dir_n = dir_q;
    wrap  = 1'b0;
    if (!en) begin
      cnt_n = '0;
      dir_n = DIR_UP;
    end else if (tick) begin
      if (prd == '0) begin
        wrap = 1'b1;
      end else if (!center) begin
        if (cnt_q >= prd - ONE) wrap = 1'b1;
        else                    cnt_n = cnt_q + ONE;
      end else if (dir_q == DIR_UP) begin
        if (cnt_q < prd)        cnt_n = cnt_q + ONE;
        else if (cnt_q == ONE)  wrap = 1'b1;
        else begin
          dir_n = DIR_DN;
          cnt_n = cnt_q - ONE;
        end
      end else begin
        if (cnt_q <= ONE) wrap = 1'b1;
        else              cnt_n = cnt_q - ONE;
      end
      if (wrap) begin
        cnt_n = '0;
        dir_n = DIR_UP;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      dir_q <= DIR_UP;
      pwm_q <= 1'b0;
      evt_q <= 1'b0;
    end else begin
      cnt_q <= cnt_n;
      dir_q <= dir_n;
      evt_q <= wrap;
      pwm_q <= en && (cnt_n < duty_nxt);
    end
  end

  assign wrap_o = wrap;
  assign cnt_o  = cnt_q;
  assign pwm_o  = pwm_q;
  assign evt_o  = evt_q;

  // R7: the period event is shown together with a zero count.
  a_r7_evt_at_zero: assert property (@(posedge clk) disable iff (rst)
    evt_q |-> (cnt_q == '0));

  // R2: an idle channel parks at zero, output low, no event.
  a_r2_idle_park: assert property (@(posedge clk) disable iff (rst)
    !en |=> (cnt_q == '0 && !pwm_q && !evt_q));

  // R4: the edge-aligned count stays below the period.
  a_r4_left_range: assert property (@(posedge clk) disable iff (rst)
    (en && !center && prd != '0) |-> (cnt_q < prd));

  // R5: the center-aligned count never passes the period.
  a_r5_center_range: assert property (@(posedge clk) disable iff (rst)
    center |-> (cnt_q <= prd));

  // R3: without a tick the count is frozen.
  a_r3_no_tick_hold: assert property (@(posedge clk) disable iff (rst)
    (en && !tick) |=> $stable(cnt_q));

endmodule

// File: rtl/pwm_ch.sv
module pwm_ch
  import pwm_ch_pkg::*;
#(
  parameter int CNT_W = 20,
  parameter int PRE_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             chan_en,
  input  logic             tick_a,
  input  logic             tick_b,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  output logic             pwm_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             evt_o
);

  mode_t            mode_act;
  logic [CNT_W-1:0] prd_act, duty_nxt;
  logic             tick, wrap, load;

  // Working copies refresh while idle and at each period boundary.
  assign load = !chan_en || wrap;

  pwm_ch_regs #(.CNT_W(CNT_W)) regs_i (
    .clk      (clk),
    .rst      (rst),
    .en       (chan_en),
    .load     (load),
    .wr_en    (wr_en),
    .wr_sel   (wr_sel),
    .wr_data  (wr_data),
    .mode_act (mode_act),
    .prd_act  (prd_act),
    .duty_nxt (duty_nxt)
  );

  pwm_ch_tick #(.PRE_W(PRE_W)) tick_i (
    .clk    (clk),
    .rst    (rst),
    .en     (chan_en),
    .src    (mode_act.src),
    .ext_a  (tick_a),
    .ext_b  (tick_b),
    .tick_o (tick)
  );

  pwm_ch_count #(.CNT_W(CNT_W)) count_i (
    .clk      (clk),
    .rst      (rst),
    .en       (chan_en),
    .tick     (tick),
    .center   (mode_act.center),
    .prd      (prd_act),
    .duty_nxt (duty_nxt),
    .wrap_o   (wrap),
    .cnt_o    (cnt_o),
    .pwm_o    (pwm_o),
    .evt_o    (evt_o)
  );

  // R1: nothing is driven on the first cycle after reset.
  a_r1_reset_quiet: assert property (@(posedge clk)
    $fell(rst) |-> (cnt_o == '0 && !pwm_o && !evt_o));

endmodule

// File: tb/pwm_ch_tb_top.sv
module pwm_ch_tb_top;
  localparam int CLK_P = 10;
  localparam int CNT_W = 20;

  logic             clk = 1'b0, rst = 1'b1, chan_en = 1'b0;
  logic             tick_a = 1'b0, tick_b = 1'b0, wr_en = 1'b0;
  logic [1:0]       wr_sel = '0;
  logic [CNT_W-1:0] wr_data = '0;
  logic             pwm_o, evt_o;
  logic [CNT_W-1:0] cnt_o;

  always #(CLK_P/2) clk = ~clk;

  pwm_ch #(.CNT_W(CNT_W), .PRE_W(10)) dut_i (
    .clk(clk), .rst(rst), .chan_en(chan_en), .tick_a(tick_a), .tick_b(tick_b),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .pwm_o(pwm_o), .cnt_o(cnt_o), .evt_o(evt_o)
  );

  int    checks = 0, errors = 0, cyc = 0;
  string cur_req = "R1";
  bit    done = 1'b0;

  // Arithmetic model: position inside the current period plus shadows.
  int m_pos = 0, m_P = 0, m_D = 0, m_k = 0, m_sel = 0, m_cnt = 0;
  bit m_c = 0, m_evt = 0, m_out = 0;
  int s_P = 0, s_D = 0, s_sel = 0;
  bit s_c = 0;

  function automatic void chk(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d (cycle %0d)", cur_req, what, act, exp, cyc);
    end
  endfunction

  function automatic void shadow_write();
    if (wr_en && wr_sel != 2'd3) begin
      case (wr_sel)
        2'd0: begin s_sel = int'(wr_data[3:0]); s_c = wr_data[4]; end
        2'd1: s_D = int'(wr_data);
        default: s_P = int'(wr_data);
      endcase
    end
  endfunction

  function automatic void take_shadow();
    m_P = s_P; m_D = s_D; m_c = s_c; m_sel = s_sel;
  endfunction

  function automatic void model_edge();
    bit tk;
    int span;
    m_evt = 1'b0;
    if (rst) begin
      m_pos = 0; m_k = 0; s_P = 0; s_D = 0; s_sel = 0; s_c = 0;
      take_shadow();
    end else if (!chan_en) begin
      m_pos = 0; m_k = 0;
      shadow_write();
      take_shadow();
    end else begin
      m_k++;
      if (m_sel <= 10)      tk = (m_k % (1 << m_sel)) == 0;
      else if (m_sel == 11) tk = tick_a;
      else if (m_sel == 12) tk = tick_b;
      else                  tk = 1'b0;
      if (tk) begin
        span = (m_P == 0) ? 1 : (m_c ? 2 * m_P : m_P);
        m_pos++;
        if (m_pos >= span) begin
          m_pos = 0; m_evt = 1'b1;
          take_shadow();
        end
      end
      shadow_write();  // R10: a write on the boundary edge waits one period
    end
    m_cnt = (m_c && m_pos > m_P) ? 2 * m_P - m_pos : m_pos;
    m_out = !rst && chan_en && (m_cnt < m_D);
  endfunction

  task automatic step();
    tick_a = (cyc % 3 == 0);
    tick_b = (cyc % 5 == 2);
    @(posedge clk);
    model_edge();
    cyc++;
    @(negedge clk);
    chk("cnt", int'(cnt_o), m_cnt);
    chk("pwm", int'(pwm_o), int'(m_out));
    chk("evt", int'(evt_o), int'(m_evt));
    wr_en = 1'b0;
  endtask

  task automatic wr(int sel, int data);
    wr_en = 1'b1; wr_sel = 2'(sel); wr_data = CNT_W'(data);
    step();
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      summary();
      $finish;
    end
  end

  initial begin
    int srcs[6] = '{0, 1, 2, 11, 12, 13};
    // R1: reset state
    cur_req = "R1";
    repeat (3) step();
    rst = 1'b0;
    // R1 R8: default settings run with period 0, event each tick, output low
    cur_req = "R1 R8";
    chan_en = 1'b1;
    repeat (6) step();
    chan_en = 1'b0;
    step();

    // Sweep of alignment, period, duty and tick source (R3 R4 R5 R6 R7 R8 R9)
    for (int c = 0; c < 2; c++) begin
      for (int p = 0; p < 6; p++) begin
        for (int d = 0; d < 7; d++) begin
          for (int s = 0; s < 6; s++) begin
            if (p == 0)      cur_req = "R8 R3";
            else if (c == 1) cur_req = "R5 R6 R7 R3";
            else             cur_req = "R4 R6 R7 R3";
            chan_en = 1'b0;
            wr(2, p);
            wr(1, d);
            cur_req = {cur_req, " R9"};
            wr(0, (c << 4) | srcs[s]);
            chan_en = 1'b1;
            repeat (48) step();
          end
        end
      end
    end

    // R9: writes while running wait for the boundary
    cur_req = "R9";
    chan_en = 1'b0;
    wr(2, 5); wr(1, 2); wr(0, 0);
    chan_en = 1'b1;
    repeat (7) step();
    wr(2, 3); wr(1, 1); wr(0, 16);
    repeat (30) step();

    // R10: period write on the very edge the counter wraps
    cur_req = "R10";
    chan_en = 1'b0;
    wr(2, 4); wr(1, 2); wr(0, 0);
    chan_en = 1'b1;
    repeat (3) step();
    wr(2, 2);
    repeat (20) step();

    // R11: counter slot write ignored
    cur_req = "R11";
    wr(3, 7);
    repeat (4) step();
    wr(3, 0);
    repeat (10) step();

    // R2: drop enable mid-run, then resume with a divided source
    cur_req = "R2";
    chan_en = 1'b0;
    wr(0, 2); wr(2, 5); wr(1, 3);
    chan_en = 1'b1;
    repeat (9) step();
    chan_en = 1'b0;
    repeat (3) step();
    chan_en = 1'b1;
    repeat (30) step();

    done = 1'b1;
    summary();
    $finish;
  end

endmodule